// File: doc/BRIEF.md
# Fixed-Point Pixel Pack and Expand Unit

This block is a single-stage datapath that moves image data between a packed pixel form (unsigned 8-bit components, four to a 32-bit word) and a partitioned signed fixed-point form (four 16-bit lanes or two 32-bit lanes in a 64-bit word). Narrowing operations apply a left shift taken from a scale input. They then round by adding one just below the bit field that is kept, and saturate the outcome to the target range instead of wrapping it. Widening operations place pixels into fixed-point lanes, or interleave two pixel words byte by byte.

The caller presents two 64-bit sources, an operation code and a 5-bit scale together with a valid strobe. The result appears in a register on the following clock edge, with a matching valid flag. When no operation is strobed, the result register keeps its value. The scale input takes the place of the scale field that a status register would otherwise hold.

Top module: `pxfx_pack_unit`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released until the first strobe, res is zero and res_valid is low.
- R2: res_valid equals in_valid from the previous clock edge. res loads only on an edge where in_valid is high, and otherwise holds its value.
- R3: Op 0 (pixel pack from 16-bit fixed) works on each signed 16-bit lane i of src_b (bits 16i+15..16i, i = 0..3). The lane is shifted left by scale[3:0], 64 is added, and the sum is shifted right arithmetically by 7. The outcome goes to res byte i, and res[63:32] is zero. scale[4] has no effect on this op.
- R4: Op 1 (pixel pack from 32-bit fixed) works on each signed 32-bit half h of src_b. The half is shifted left by scale[4:0], 2^22 is added, and the sum is shifted right arithmetically by 23, giving a pixel. Result half h is the matching half of src_a shifted left by 8 bits, with that pixel in its low byte.
- R5: Op 2 (fixed narrowing) works on each signed 32-bit half h of src_b. The half is shifted left by scale[4:0], 2^15 is added, and the sum is shifted right arithmetically by 16. The outcome is written to res[16h+15:16h], and res[63:32] is zero.
- R6: Op 3 (expand) places byte i of src_b[31:0] in res[16i+11:16i+4]. All other result bits are zero.
- R7: Op 4 (merge) takes A = src_a[31:0] and B = src_b[31:0] and gives res = {A3,B3,A2,B2,A1,B1,A0,B0}, listed from the most significant byte down.
- R8: The pixel packs (ops 0 and 1) clip negative outcomes to 0 and outcomes above 255 to 255. The fixed narrowing (op 2) clips to the range -32768..32767.
- R9: A value that lies exactly halfway between two outputs rounds upward. For op 0 at scale 0, an input of 64 gives 1 and an input of 63 gives 0.
- R10: Op codes 5, 6 and 7 give an all-zero result, and res_valid is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that accepts an operation this cycle |
| op | input | 3 | Operation code (0..4 defined, 5..7 give zero) |
| src_a | input | 64 | First source (destination bytes for op 1, A word for op 4) |
| src_b | input | 64 | Second source (lanes to narrow, pixels to expand or merge) |
| scale | input | 5 | Left-shift amount applied before narrowing |
| res | output | 64 | Registered result |
| res_valid | output | 1 | High for one cycle after each accepted operation |

## Verification
The only state in the block is the result register and its valid flag, so any fault shows at the ports on the edge that follows the strobe. A lane that rounds or clips wrongly corrupts exactly one byte or halfword of res, and no other part of the result. A fault in the load-enable logic shows up on the idle cycles that follow: res changes when no strobe is present, or res_valid does not track in_valid.

// File: rtl/pxfx_pkg.sv
package pxfx_pkg;
  localparam int PIX_W    = 8;
  localparam int WORD_W   = 64;
  localparam int HALF_W   = WORD_W / 2;
  localparam int PIX_PER  = HALF_W / PIX_W;   // pixels per 32-bit pixel word
  localparam int F16_W    = 16;
  localparam int F16_N    = WORD_W / F16_W;
  localparam int F32_N    = WORD_W / HALF_W;
  localparam int SCALE_W  = 5;

  typedef enum logic [2:0] {
    OP_PACK16  = 3'd0,
    OP_PACK32  = 3'd1,
    OP_PACKFIX = 3'd2,
    OP_EXPAND  = 3'd3,
    OP_MERGE   = 3'd4
  } pxfx_op_e;

  // pixel i lands in bits [11:4] of 16-bit lane i
  function automatic logic [WORD_W-1:0] expand_pixels(input logic [HALF_W-1:0] px);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < PIX_PER; i++)
      w[i*F16_W+4 +: PIX_W] = px[i*PIX_W +: PIX_W];
    return w;
  endfunction

  // byte-wise interleave, A byte above B byte at each position
  function automatic logic [WORD_W-1:0] interleave(input logic [HALF_W-1:0] a,
                                                   input logic [HALF_W-1:0] b);
    logic [WORD_W-1:0] w;
    for (int i = 0; i < PIX_PER; i++) begin
      w[(2*i+1)*PIX_W +: PIX_W] = a[i*PIX_W +: PIX_W];
      w[(2*i)*PIX_W   +: PIX_W] = b[i*PIX_W +: PIX_W];
    end
    return w;
  endfunction
endpackage

// File: rtl/pxfx_narrow_lane.sv
module pxfx_narrow_lane #(
  parameter int IN_W       = 16,
  parameter int SH_W       = 4,
  parameter int DROP       = 7,
  parameter int OUT_W      = 8,
  parameter bit SIGNED_OUT = 1'b0
) (
  input  logic [IN_W-1:0]  lane_in,
  input  logic [SH_W-1:0]  shamt,
  output logic [OUT_W-1:0] lane_out,
  output logic             clip_hi,
  output logic             clip_lo
);
  localparam int WIDE_W = IN_W + 2**SH_W;
  localparam logic signed [WIDE_W-1:0] ONE    = {{(WIDE_W-1){1'b0}}, 1'b1};
  localparam logic signed [WIDE_W-1:0] RND    = ONE <<< (DROP-1);
  localparam logic signed [WIDE_W-1:0] HI_LIM = SIGNED_OUT ? ((ONE <<< (OUT_W-1)) - ONE)
                                                           : ((ONE <<< OUT_W) - ONE);
  localparam logic signed [WIDE_W-1:0] LO_LIM = SIGNED_OUT ? -(ONE <<< (OUT_W-1))
                                                           : {WIDE_W{1'b0}};

  logic signed [WIDE_W-1:0] ext, shifted, rounded, q;

  always_comb begin
    ext      = {{(WIDE_W-IN_W){lane_in[IN_W-1]}}, lane_in};
    shifted  = ext <<< shamt;
    rounded  = shifted + RND;
    q        = rounded >>> DROP;
    clip_hi  = (q > HI_LIM);
    clip_lo  = (q < LO_LIM);
    if (clip_hi)      lane_out = HI_LIM[OUT_W-1:0];
    else if (clip_lo) lane_out = LO_LIM[OUT_W-1:0];
    else              lane_out = q[OUT_W-1:0];
  end
endmodule

// File: rtl/pxfx_pixel_ops.sv
module pxfx_pixel_ops
  import pxfx_pkg::*;
(
  input  logic [HALF_W-1:0] word_a,
  input  logic [HALF_W-1:0] word_b,
  output logic [WORD_W-1:0] expanded,
  output logic [WORD_W-1:0] merged
);
  assign expanded = expand_pixels(word_b);
  assign merged   = interleave(word_a, word_b);
endmodule

// File: rtl/pxfx_pack_unit.sv
module pxfx_pack_unit
  import pxfx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [2:0]         op,
  input  logic [WORD_W-1:0]  src_a,
  input  logic [WORD_W-1:0]  src_b,
  input  logic [SCALE_W-1:0] scale,
  output logic [WORD_W-1:0]  res,
  output logic               res_valid
);
  // named internal events, visible to the bound checker
  logic [F16_N-1:0][PIX_W-1:0] p16_px;
  logic [F16_N-1:0]            p16_hi, p16_lo;
  logic [F32_N-1:0][PIX_W-1:0] p32_px;
  logic [F32_N-1:0]            p32_hi, p32_lo;
  logic [F32_N-1:0][F16_W-1:0] fx_val;
  logic [F32_N-1:0]            fx_hi, fx_lo;
  logic [WORD_W-1:0]           exp_word, mrg_word, nxt;

  for (genvar g = 0; g < F16_N; g++) begin : g_p16
    pxfx_narrow_lane #(.IN_W(F16_W), .SH_W(SCALE_W-1), .DROP(7),
                       .OUT_W(PIX_W), .SIGNED_OUT(1'b0)) u_lane (
      .lane_in (src_b[g*F16_W +: F16_W]),
      .shamt   (scale[SCALE_W-2:0]),
      .lane_out(p16_px[g]),
      .clip_hi (p16_hi[g]),
      .clip_lo (p16_lo[g])
    );
  end

  for (genvar g = 0; g < F32_N; g++) begin : g_p32
    pxfx_narrow_lane #(.IN_W(HALF_W), .SH_W(SCALE_W), .DROP(23),
                       .OUT_W(PIX_W), .SIGNED_OUT(1'b0)) u_pix (
      .lane_in (src_b[g*HALF_W +: HALF_W]),
      .shamt   (scale),
      .lane_out(p32_px[g]),
      .clip_hi (p32_hi[g]),
      .clip_lo (p32_lo[g])
    );
    pxfx_narrow_lane #(.IN_W(HALF_W), .SH_W(SCALE_W), .DROP(16),
                       .OUT_W(F16_W), .SIGNED_OUT(1'b1)) u_fix (
      .lane_in (src_b[g*HALF_W +: HALF_W]),
      .shamt   (scale),
      .lane_out(fx_val[g]),
      .clip_hi (fx_hi[g]),
      .clip_lo (fx_lo[g])
    );
  end

  pxfx_pixel_ops u_pix_ops (
    .word_a  (src_a[HALF_W-1:0]),
    .word_b  (src_b[HALF_W-1:0]),
    .expanded(exp_word),
    .merged  (mrg_word)
  );

  always_comb begin
    nxt = '0;
    case (pxfx_op_e'(op))
      OP_PACK16:  nxt[HALF_W-1:0] = p16_px;
      OP_PACK32: begin
        for (int h = 0; h < F32_N; h++)
          nxt[h*HALF_W +: HALF_W] = {src_a[h*HALF_W +: HALF_W-PIX_W], p32_px[h]};
      end
      OP_PACKFIX: nxt[HALF_W-1:0] = fx_val;
      OP_EXPAND:  nxt = exp_word;
      OP_MERGE:   nxt = mrg_word;
      default:    nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res       <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res <= nxt;
    end
  end
endmodule

// File: rtl/pxfx_pack_chk.sv
module pxfx_pack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op,
  input logic [63:0] src_a,
  input logic [63:0] src_b,
  input logic [63:0] res,
  input logic        res_valid,
  input logic [3:0]  p16_hi,
  input logic [3:0]  p16_lo,
  input logic [1:0]  p32_hi,
  input logic [1:0]  p32_lo,
  input logic [1:0]  fx_hi,
  input logic [1:0]  fx_lo
);
  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid); // R2
  AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid); // R2
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res)); // R2
  AST_PACK16_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd0) |=> (res[63:32] == 32'd0)); // R3
  AST_PACK32_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd1) |=> (res[63:40] == $past(src_a[55:32]) &&
                                  res[31:8]  == $past(src_a[23:0]))); // R4
  AST_EXPAND_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd3) |=> ((res & 64'hF00F_F00F_F00F_F00F) == 64'd0)); // R6
  AST_MERGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd4) |=> (res[63:56] == $past(src_a[31:24]) &&
                                  res[7:0]   == $past(src_b[7:0]))); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > 3'd4) |=> (res == 64'd0)); // R10

  for (genvar g = 0; g < 4; g++) begin : g_c16
    AST_PIX16_CLIP_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd0 && p16_lo[g]) |=> (res[g*8 +: 8] == 8'h00)); // R8
    AST_PIX16_CLIP_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd0 && p16_hi[g]) |=> (res[g*8 +: 8] == 8'hFF)); // R8
  end
  for (genvar g = 0; g < 2; g++) begin : g_c32
    AST_PIX32_CLIP_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd1 && p32_lo[g]) |=> (res[g*32 +: 8] == 8'h00)); // R8
    AST_PIX32_CLIP_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd1 && p32_hi[g]) |=> (res[g*32 +: 8] == 8'hFF)); // R8
    AST_FIX_CLIP_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd2 && fx_lo[g]) |=> (res[g*16 +: 16] == 16'h8000)); // R8
    AST_FIX_CLIP_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == 3'd2 && fx_hi[g]) |=> (res[g*16 +: 16] == 16'h7FFF)); // R8
  end
endmodule

bind pxfx_pack_unit pxfx_pack_chk i_pxfx_pack_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .op       (op),
  .src_a    (src_a),
  .src_b    (src_b),
  .res      (res),
  .res_valid(res_valid),
  .p16_hi   (p16_hi),
  .p16_lo   (p16_lo),
  .p32_hi   (p32_hi),
  .p32_lo   (p32_lo),
  .fx_hi    (fx_hi),
  .fx_lo    (fx_lo)
);

// File: tb/test_pxfx_pack_unit.sv
module test_pxfx_pack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [4:0]  scale = '0;
  logic [63:0] res;
  logic        res_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  pxfx_pack_unit i_pxfx_pack_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .scale(scale),
    .res(res), .res_valid(res_valid)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // floor-division reference of shift, half-up round and clip
  function automatic longint narrow(longint v, int s, int drop, longint lo, longint hi);
    longint t, d;
    d = 64'sd1 << drop;
    t = v * (64'sd1 << s) + d / 2;
    if (t >= 0) t = t / d;
    else        t = -((-t + d - 1) / d);
    if (t > hi) t = hi;
    if (t < lo) t = lo;
    return t;
  endfunction

  task automatic apply(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b, input logic [4:0] s);
    @(negedge clk);
    op = o; src_a = a; src_b = b; scale = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_pack16(input logic [63:0] b, input logic [4:0] s, input string req);
    logic [63:0] e = '0;
    for (int i = 0; i < 4; i++)
      e[i*8 +: 8] = 8'(narrow(longint'($signed(b[i*16 +: 16])), int'(s[3:0]), 7, 0, 255));
    apply(3'd0, 64'hDEAD_BEEF_0123_4567, b, s);
    check(res == e && res_valid, req, res, e);
  endtask

  task automatic t_pack32(input logic [63:0] a, input logic [63:0] b, input logic [4:0] s, input string req);
    logic [63:0] e;
    for (int h = 0; h < 2; h++)
      e[h*32 +: 32] = {a[h*32 +: 24], 8'(narrow(longint'($signed(b[h*32 +: 32])), int'(s), 23, 0, 255))};
    apply(3'd1, a, b, s);
    check(res == e && res_valid, req, res, e);
  endtask

  task automatic t_packfix(input logic [63:0] b, input logic [4:0] s, input string req);
    logic [63:0] e = '0;
    for (int h = 0; h < 2; h++)
      e[h*16 +: 16] = 16'(narrow(longint'($signed(b[h*32 +: 32])), int'(s), 16, -32768, 32767));
    apply(3'd2, 64'hFFFF_FFFF_FFFF_FFFF, b, s);
    check(res == e && res_valid, req, res, e);
  endtask

  task automatic t_expand(input logic [63:0] b);
    logic [63:0] e = '0;
    for (int i = 0; i < 4; i++) e[i*16 + 4 +: 8] = b[i*8 +: 8];
    apply(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, b, 5'd31);
    check(res == e, "R6 expand", res, e);
  endtask

  task automatic t_merge(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] e;
    e = {a[31:24], b[31:24], a[23:16], b[23:16], a[15:8], b[15:8], a[7:0], b[7:0]};
    apply(3'd4, a, b, 5'd0);
    check(res == e, "R7 merge order", res, e);
  endtask

  task automatic t_reserved();
    for (int o = 5; o < 8; o++) begin
      apply(3'(o), 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 5'd3);
      check(res == 64'd0 && res_valid, "R10 reserved op", res, 64'd0);
    end
  endtask

  task automatic t_hold();
    logic [63:0] keep;
    t_merge(64'h0000_0000_A1A2_A3A4, 64'h0000_0000_B1B2_B3B4);
    keep = res;
    @(negedge clk);
    op = 3'd3; src_a = '1; src_b = 64'h5555_5555_5555_5555; scale = 5'd7;
    @(negedge clk);
    check(res_valid == 1'b0, "R2 valid drops", {63'd0, res_valid}, 64'd0);
    repeat (2) @(negedge clk);
    check(res == keep, "R2 result held while idle", res, keep);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(res == 64'd0 && res_valid == 1'b0, "R1 reset state", res, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res == 64'd0 && res_valid == 1'b0, "R1 idle after reset", res, 64'd0);

    t_pack16(64'h0100_0080_0200_7FFF, 5'd0, "R3 pack16 scale 0");
    t_pack16(64'h0123_0045_0010_0007, 5'd4, "R3 pack16 scale 4");
    t_pack16(64'h0123_0045_0010_0007, 5'd20, "R3 scale[4] ignored");
    t_pack16(64'h8000_FFFF_7FFF_0300, 5'd2, "R8 pack16 clip");
    t_pack16(64'h0000_003F_0040_00BF, 5'd0, "R9 half rounds up");
    t_pack32(64'h1122_3344_5566_7788, 64'h0080_0000_3F80_0000, 5'd0, "R4 pack32 basic");
    t_pack32(64'hA0B0_C0D0_0102_0304, 64'h0001_2345_0000_4000, 5'd9, "R4 pack32 scaled");
    t_pack32(64'h0, 64'h8000_0000_7FFF_FFFF, 5'd31, "R8 pack32 clip");
    t_packfix(64'h0001_8000_FFFE_8000, 5'd0, "R5 fixed narrow");
    t_packfix(64'h0000_1234_FFFF_F000, 5'd12, "R5 fixed scaled");
    t_packfix(64'h7FFF_FFFF_8000_0000, 5'd1, "R8 fixed clip");
    t_expand(64'hFFFF_FFFF_80FF_017F);
    t_expand(64'h0000_0000_0000_0000);
    t_merge(64'hFFFF_FFFF_0011_2233, 64'h0000_0000_4455_6677);
    t_reserved();
    t_hold();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule